// File: doc/BRIEF.md
# SPI Slave Transceiver with Arming

This block is a word-oriented SPI slave. An external master selects it with an active-low select line and clocks bits in and out over the master's own serial clock. Every word is a full-duplex exchange: one word arrives on MOSI while one word leaves on MISO.

Software has to prepare each transfer. It first writes a transmit word into a one-word buffer, then writes a start command that arms the block. Words leave only while the block is armed and the buffer holds data. Once the data runs out, the block disarms itself and drives logic ones for as long as the master keeps it selected. Each received word lands in a readable register.

Two event flags report progress: the transmit buffer has been drained, and a word has been received. Each flag has its own mask bit, and the masked flags are ORed onto a single interrupt line. The serial pins are resampled into the system clock domain, so the serial clock must stay well below the system clock rate.

Top module: `spis_xcvr`

## Requirements
- R1: After reset, all four register addresses read zero, `irq` is low and `spi_miso_oe` is low.
- R2: Serial clock edges that arrive while `spi_sel_n` is high have no effect: they produce no receive event and do not shift the bit position of the next transfer.
- R3: The mode is clock-idle-low with sampling on the leading edge. MOSI is sampled on the rising edge of `spi_sck` and MISO changes after the falling edge. Words are 8 bits wide and travel most significant bit first. The first MISO bit is valid before the first rising edge.
- R4: A word written to the data address (0) is sent only after a write of 1 to bit 0 of the command address (1). Without that write, the block sends 0xFF and the word stays buffered. Reading address 1 gives the armed state on bit 0 and the buffer-full state on bit 1.
- R5: Event bit 0 at address 2 (transmit event) sets in the cycle after the buffered word moves into the shifter.
- R6: Event bit 1 at address 2 (receive event) sets when the eighth bit of a word has been sampled. The received word can then be read at address 0.
- R7: While still armed, the block loads a word written during a transfer at the next word boundary. At a boundary where no word is buffered, the block disarms and sends 0xFF for every further word.
- R8: If select rises in the middle of a word, the partial word is dropped, no receive event occurs, and the next transfer starts again at bit 7.
- R9: `irq` is high exactly when some event bit and its mask bit at address 3 (same bit positions) are both set.
- R10: Event bits clear only when a 1 is written to their position at address 2. Writing 0 leaves them unchanged.
- R11: `spi_miso_oe` is high only while the block is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO driver |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench sends a buffered word without arming the block. A design that ignores the start command would put 0x A5 on MISO instead of 0xFF. A multi-word session has the next word written in the middle of a transfer and then lets the data run out. A wrong reload point would repeat, drop or shift a word, and a missing disarm would resend stale data. Select is released after three bits, and the clock is toggled while the block is deselected. If the bit counter were not cleared, or deselected edges were counted, the following word would come back rotated or a false receive event would appear. Writing zero to the event register, and setting an event whose mask bit is off, catches a flag that clears on any write and an interrupt that ignores its mask.

// File: rtl/spis_pkg.sv
package spis_pkg;
   // register addresses
   localparam logic [1:0] ADR_DATA = 2'd0;
   localparam logic [1:0] ADR_CMD  = 2'd1;
   localparam logic [1:0] ADR_EVT  = 2'd2;
   localparam logic [1:0] ADR_MSK  = 2'd3;
   // event / mask bit positions
   localparam int EV_TX = 0;
   localparam int EV_RX = 1;
   localparam int EV_N  = 2;
   // command bits
   localparam int CMD_START = 0;
   // status bits readable at ADR_CMD
   localparam int ST_ARMED = 0;
   localparam int ST_FULL  = 1;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic [W-1:0] rst_val,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spis_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= rst_val;
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spis_shifter.sv
module spis_shifter #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              sel_act,
   input  logic              mosi_s,
   input  logic              tx_avail,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_slot,
   output logic              tx_take,
   output logic              word_done,
   output logic [WORD_W-1:0] rx_word,
   output logic              miso
);
   localparam int              CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic              sck_d, sel_d, pend;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] tx_sh, rx_sh, rx_next, tx_next;
   logic              rise, fall, sel_start;

   // bit order variant
   generate
      if (MSB_FIRST) begin : g_msb
         assign miso    = tx_sh[WORD_W-1];
         assign rx_next = {rx_sh[WORD_W-2:0], mosi_s};
         assign tx_next = {tx_sh[WORD_W-2:0], 1'b1};
      end else begin : g_lsb
         assign miso    = tx_sh[0];
         assign rx_next = {mosi_s, rx_sh[WORD_W-1:1]};
         assign tx_next = {1'b1, tx_sh[WORD_W-1:1]};
      end
   endgenerate

   // edges count only once select has been seen for a full cycle
   assign rise      = sel_act & sel_d & sck_s & ~sck_d;
   assign fall      = sel_act & sel_d & ~sck_s & sck_d;
   assign sel_start = sel_act & ~sel_d;
   assign tx_slot   = sel_start | (fall & pend);
   assign tx_take   = tx_slot & tx_avail;
   assign word_done = rise & (cnt == LAST);
   assign rx_word   = rx_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         sel_d <= 1'b0;
         pend  <= 1'b0;
         cnt   <= '0;
         rx_sh <= '0;
         tx_sh <= '1;
      end else begin
         sck_d <= sck_s;
         sel_d <= sel_act;
         if (!sel_act) begin
            // deselect: drop any partial word
            pend  <= 1'b0;
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '1;
         end else begin
            if (tx_slot)   tx_sh <= tx_avail ? tx_word : '1;
            else if (fall) tx_sh <= tx_next;
            if (fall) pend <= 1'b0;
            if (rise) begin
               rx_sh <= rx_next;
               if (cnt == LAST) begin
                  cnt  <= '0;
                  pend <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_act |=> (cnt == '0) && !pend);

   assert_miso_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_act && $past(sel_act) && !$past(fall) && !$past(sel_start)) |-> $stable(tx_sh));
endmodule

// File: rtl/spis_regs.sv
module spis_regs
   import spis_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              tx_slot,
   input  logic              tx_take,
   input  logic              word_done,
   input  logic [WORD_W-1:0] rx_word,
   output logic              tx_avail,
   output logic [WORD_W-1:0] tx_word,
   output logic              irq
);
   logic [WORD_W-1:0] tx_buf, rx_buf;
   logic              tx_full, armed;
   logic [EV_N-1:0]   ev, mask, ev_clr, ev_set;

   assign ev_clr = (reg_wr && reg_addr == ADR_EVT) ? reg_wdata[EV_N-1:0] : '0;
   always_comb begin
      ev_set        = '0;
      ev_set[EV_TX] = tx_take;
      ev_set[EV_RX] = word_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf  <= '0;
         rx_buf  <= '0;
         tx_full <= 1'b0;
         armed   <= 1'b0;
         ev      <= '0;
         mask    <= '0;
      end else begin
         if (tx_take) tx_full <= 1'b0;
         if (reg_wr && reg_addr == ADR_DATA) begin
            tx_buf  <= reg_wdata;
            tx_full <= 1'b1;
         end
         if (tx_slot && !tx_full) armed <= 1'b0;
         if (reg_wr && reg_addr == ADR_CMD && reg_wdata[CMD_START]) armed <= 1'b1;
         if (word_done) rx_buf <= rx_word;
         ev <= (ev & ~ev_clr) | ev_set;
         if (reg_wr && reg_addr == ADR_MSK) mask <= reg_wdata[EV_N-1:0];
      end
   end

   assign tx_avail = armed & tx_full;
   assign tx_word  = tx_buf;
   assign irq      = |(ev & mask);

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADR_DATA: reg_rdata = rx_buf;
         ADR_CMD: begin
            reg_rdata[ST_ARMED] = armed;
            reg_rdata[ST_FULL]  = tx_full;
         end
         ADR_EVT: reg_rdata[EV_N-1:0] = ev;
         default: reg_rdata[EV_N-1:0] = mask;
      endcase
   end

   assert_tx_event_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev[EV_TX]) |-> $past(tx_take));

   assert_rx_event_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev[EV_RX]) |-> $past(word_done));

   assert_take_when_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> (armed && tx_full));

   assert_event_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr || reg_addr != ADR_EVT) |=> ((ev & $past(ev)) == $past(ev)));
endmodule

// File: rtl/spis_xcvr.sv
module spis_xcvr
   import spis_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_sel_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int            PIN_N   = 3;
   localparam logic [PIN_N-1:0] PIN_RST = 3'b010; // {sck, sel_n, mosi}

   generate
      if (WORD_W < EV_N) begin : g_bad_width
         $error("spis_xcvr: WORD_W too narrow for the event register");
      end
   endgenerate

   logic [PIN_N-1:0]  pins_s;
   logic              sck_s, sel_act, mosi_s;
   logic              tx_slot, tx_take, word_done, tx_avail;
   logic [WORD_W-1:0] rx_word, tx_word;

   spis_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d       ({spi_sck, spi_sel_n, spi_mosi}),
      .rst_val (PIN_RST),
      .q       (pins_s)
   );

   assign sck_s   = pins_s[2];
   assign sel_act = ~pins_s[1];
   assign mosi_s  = pins_s[0];

   spis_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .sel_act   (sel_act),
      .mosi_s    (mosi_s),
      .tx_avail  (tx_avail),
      .tx_word   (tx_word),
      .tx_slot   (tx_slot),
      .tx_take   (tx_take),
      .word_done (word_done),
      .rx_word   (rx_word),
      .miso      (spi_miso)
   );

   spis_regs #(.WORD_W(WORD_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tx_slot   (tx_slot),
      .tx_take   (tx_take),
      .word_done (word_done),
      .rx_word   (rx_word),
      .tx_avail  (tx_avail),
      .tx_word   (tx_word),
      .irq       (irq)
   );

   assign spi_miso_oe = sel_act;

   assert_done_only_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> !pins_s[1]);
endmodule

// File: tb/tb_spis_xcvr.sv
module tb_spis_xcvr;
   localparam int W    = 8;
   localparam int HALF = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sck = 1'b0, sel_n = 1'b1, mosi = 1'b0, wr = 1'b0;
   logic [1:0]   addr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic         miso, oe, irq;
   logic [W-1:0] rdata;
   int           checks = 0, errors = 0;
   bit           done = 1'b0;

   always #2 clk = ~clk;

   spis_xcvr dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_sel_n(sel_n), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(oe), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [W-1:0] d);
      @(posedge clk); #1 wr = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1 wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [W-1:0] d);
      @(posedge clk); #1 addr = a;
      #1 d = rdata;
   endtask

   task automatic sel_on;  sel_n = 1'b0; tick(HALF); endtask
   task automatic sel_off; sel_n = 1'b1; tick(HALF); endtask

   task automatic word(input logic [W-1:0] mo, output logic [W-1:0] mi);
      for (int i = W - 1; i >= 0; i--) begin
         mosi = mo[i];
         tick(HALF);
         mi[i] = miso;
         sck = 1'b1;
         tick(HALF);
         sck = 1'b0;
      end
      tick(HALF);
   endtask

   task automatic t_reset;
      logic [W-1:0] v;
      for (int a = 0; a < 4; a++) begin
         rreg(a[1:0], v);
         chk("R1 register after reset", v, 0);
      end
      chk("R1 irq after reset", irq, 0);
      chk("R1 oe after reset", oe, 0);
   endtask

   task automatic t_no_arm;
      logic [W-1:0] mi, v;
      wreg(2'd0, 8'hA5);
      sel_on();
      chk("R11 oe while selected", oe, 1);
      word(8'h3C, mi);
      sel_off();
      chk("R11 oe after deselect", oe, 0);
      chk("R4 unarmed sends ones", mi, 8'hFF);
      rreg(2'd0, v);
      chk("R3 received word", v, 8'h3C);
      rreg(2'd2, v);
      chk("R6 rx event only", v, 8'h02);
      rreg(2'd1, v);
      chk("R4 buffer still full, not armed", v, 8'h02);
   endtask

   task automatic t_armed;
      logic [W-1:0] mi, v;
      wreg(2'd2, 8'h03);
      wreg(2'd1, 8'h01);
      rreg(2'd1, v);
      chk("R4 armed and full", v, 8'h03);
      sel_on();
      word(8'hC3, mi);
      chk("R4 armed sends buffer", mi, 8'hA5);
      rreg(2'd0, v);
      chk("R3 received word armed", v, 8'hC3);
      rreg(2'd2, v);
      chk("R5 tx event set", v[0], 1);
      word(8'h00, mi);
      sel_off();
      chk("R7 ones after data runs out", mi, 8'hFF);
      rreg(2'd1, v);
      chk("R7 disarmed and empty", v, 8'h00);
      wreg(2'd2, 8'h03);
      rreg(2'd2, v);
      chk("R10 write one clears", v, 8'h00);
   endtask

   task automatic t_stream;
      logic [W-1:0] m1, m2, m3, v;
      wreg(2'd0, 8'h11);
      wreg(2'd1, 8'h01);
      sel_on();
      fork
         word(8'h81, m1);
         begin tick(4 * HALF); wreg(2'd0, 8'h22); end
      join
      word(8'h42, m2);
      rreg(2'd0, v);
      chk("R6 second word received", v, 8'h42);
      word(8'h24, m3);
      sel_off();
      chk("R7 first streamed word", m1, 8'h11);
      chk("R7 mid-transfer write sent next", m2, 8'h22);
      chk("R7 ones when drained", m3, 8'hFF);
      rreg(2'd1, v);
      chk("R7 disarmed after drain", v, 8'h00);
      wreg(2'd2, 8'h03);
   endtask

   task automatic t_glitch;
      logic [W-1:0] mi, v;
      sel_on();
      for (int i = 0; i < 3; i++) begin
         mosi = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
      end
      tick(HALF);
      sel_off();
      rreg(2'd2, v);
      chk("R8 no rx event on partial word", v, 8'h00);
      sel_on();
      word(8'h5A, mi);
      sel_off();
      rreg(2'd0, v);
      chk("R8 next word aligned", v, 8'h5A);
      wreg(2'd2, 8'h03);
   endtask

   task automatic t_ignore;
      logic [W-1:0] mi, v;
      for (int i = 0; i < 5; i++) begin
         mosi = i[0]; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
      end
      tick(HALF);
      rreg(2'd2, v);
      chk("R2 no event while deselected", v, 8'h00);
      sel_on();
      word(8'h96, mi);
      sel_off();
      rreg(2'd0, v);
      chk("R2 word unaffected by idle clocks", v, 8'h96);
   endtask

   task automatic t_irq;
      logic [W-1:0] mi, v;
      wreg(2'd2, 8'h03);
      wreg(2'd3, 8'h00);
      sel_on();
      word(8'h0F, mi);
      sel_off();
      chk("R9 irq low with mask off", irq, 0);
      wreg(2'd3, 8'h01);
      chk("R9 irq low, only tx masked in", irq, 0);
      wreg(2'd3, 8'h02);
      chk("R9 irq high with rx masked in", irq, 1);
      wreg(2'd2, 8'h00);
      rreg(2'd2, v);
      chk("R10 write zero keeps event", v, 8'h02);
      wreg(2'd2, 8'h02);
      rreg(2'd2, v);
      chk("R10 event cleared", v, 8'h00);
      chk("R9 irq low after clear", irq, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_no_arm();
      t_armed();
      t_stream();
      t_glitch();
      t_ignore();
      t_irq();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule